// File: doc/BRIEF.md
# D-Channel Transmit Busy Watchdog

This block watches each transmit burst of an HDLC D-channel controller. Whenever the host loads a block into the transmitter, a timeout of `TIMEOUT_MS` milliseconds, 80 by default, starts again from zero. The timeout is counted in milliseconds derived from a base tick-enable input. A ready-for-more report or an underrun report from the transmitter stops the timeout.

If the timeout runs out, the block samples a channel-access-busy status input in that same cycle. When access is blocked, the block sets a busy flag and emits a one-cycle pause indication. It stays armed but produces no further outcome for that arming. When access is free, the frame is abandoned: the armed flag drops and the block emits a one-cycle discard pulse together with a one-cycle transmitter-reset pulse.

The busy flag is cleared, with a one-cycle resume event, by the next ready report, the next underrun report, or a deactivate request. A deactivate request also stops the timer.

Top module: `dchan_busy_watchdog`

## Requirements
- R1: After synchronous reset, armed_o, busy_o, pause_o, resume_o, discard_o and txrst_o are all 0.
- R2: The timeout expires at the clock edge on which the TICKS_PER_MS*TIMEOUT_MS-th tick_i high cycle after the load edge is sampled. Cycles with tick_i low do not advance the timer.
- R3: A load_i pulse while armed restarts the timeout from zero.
- R4: ready_i or underrun_i clears armed_o, and no expiry outcome follows. If load_i is high in the same cycle, load_i wins and the timer restarts armed.
- R5: On expiry with access_busy_i = 1, busy_o becomes 1, pause_o pulses for exactly one cycle, and armed_o stays 1.
- R6: On expiry with access_busy_i = 0, armed_o becomes 0, and discard_o and txrst_o pulse together for exactly one cycle.
- R7: ready_i or underrun_i while busy_o = 1 clears busy_o and pulses resume_o for one cycle. With busy_o = 0, no resume is produced.
- R8: deact_i clears armed_o and busy_o, and pulses resume_o if busy_o was 1. deact_i has priority over load_i.
- R9: Each arming produces at most one expiry outcome (pause, or discard plus reset), never both and never repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base time tick enable, TICKS_PER_MS per millisecond |
| load_i | input | 1 | Host loaded a transmit block (arm/restart) |
| ready_i | input | 1 | Transmitter ready for more data |
| underrun_i | input | 1 | Transmitter underrun reported |
| deact_i | input | 1 | Deactivate request |
| access_busy_i | input | 1 | Channel access blocked status |
| armed_o | output | 1 | Timer armed |
| busy_o | output | 1 | Channel busy flag |
| pause_o | output | 1 | One-cycle pause indication |
| resume_o | output | 1 | One-cycle busy-cleared indication |
| discard_o | output | 1 | One-cycle frame discard |
| txrst_o | output | 1 | One-cycle transmitter reset command |

## Verification
Expiry is tried with tick_i held high and with long stretches of tick_i low, which shows that only tick cycles count and that the expiry edge is exact. A reload in mid-count tells restart apart from ignore. The status input is driven both ways at expiry to separate the pause path from the discard path. Ready, underrun and deactivate are each applied with the busy flag set and with it clear, which shows that resume depends on the prior busy state and that deactivate outranks a simultaneous load.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef struct packed {
    logic pause;
    logic resume;
    logic discard;
    logic txrst;
  } txw_evt_t;
endpackage

// File: rtl/txw_tick_timer.sv
module txw_tick_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int TIMEOUT_MS   = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic load_i,
  input  logic stop_i,
  input  logic deact_i,
  input  logic keep_i,
  output logic armed_o,
  output logic expire_o
);
  localparam int SUB_W = $clog2(TICKS_PER_MS > 1 ? TICKS_PER_MS : 2);
  localparam int MS_W  = $clog2(TIMEOUT_MS > 1 ? TIMEOUT_MS : 2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(TIMEOUT_MS - 1);

  logic [SUB_W-1:0] sub_q;
  logic [MS_W-1:0]  ms_q;
  logic             armed_q;
  logic             fired_q;
  logic             counting;

  assign counting = armed_q && !fired_q && tick_i;
  assign expire_o = counting && sub_q == SUB_LAST && ms_q == MS_LAST
                    && !deact_i && !load_i && !stop_i;
  assign armed_o  = armed_q;

  always_ff @(posedge clk) begin
    if (rst || deact_i) begin
      armed_q <= 1'b0;
      fired_q <= 1'b0;
      sub_q   <= '0;
      ms_q    <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      fired_q <= 1'b0;
      sub_q   <= '0;
      ms_q    <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
      fired_q <= 1'b0;
      sub_q   <= '0;
      ms_q    <= '0;
    end else if (expire_o) begin
      if (keep_i) fired_q <= 1'b1;
      else        armed_q <= 1'b0;
      sub_q <= '0;
      ms_q  <= '0;
    end else if (counting) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ms_q <= MS_LAST) else $error("ms count out of range"); // R2
  AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sub_q <= SUB_LAST) else $error("sub count out of range"); // R2
endmodule

// File: rtl/txw_busy_ctrl.sv
module txw_busy_ctrl
  import txw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     expire_i,
  input  logic     access_busy_i,
  input  logic     clear_i,
  output logic     busy_o,
  output txw_evt_t evt_o
);
  logic busy_q;

  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      evt_o  <= '0;
    end else begin
      evt_o.pause   <= expire_i && access_busy_i;
      evt_o.discard <= expire_i && !access_busy_i;
      evt_o.txrst   <= expire_i && !access_busy_i;
      evt_o.resume  <= busy_q && clear_i;
      if (clear_i)                        busy_q <= 1'b0;
      else if (expire_i && access_busy_i) busy_q <= 1'b1;
    end
  end

  AST_RESUME_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    evt_o.resume |-> !busy_q && $past(busy_q)) else $error("resume w/o busy"); // R7
endmodule

// File: rtl/dchan_busy_watchdog.sv
module dchan_busy_watchdog
  import txw_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int TIMEOUT_MS   = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic load_i,
  input  logic ready_i,
  input  logic underrun_i,
  input  logic deact_i,
  input  logic access_busy_i,
  output logic armed_o,
  output logic busy_o,
  output logic pause_o,
  output logic resume_o,
  output logic discard_o,
  output logic txrst_o
);
  logic     stop;
  logic     expire;
  txw_evt_t evt;

  assign stop = ready_i || underrun_i;

  txw_tick_timer #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .TIMEOUT_MS  (TIMEOUT_MS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .load_i  (load_i),
    .stop_i  (stop),
    .deact_i (deact_i),
    .keep_i  (access_busy_i),
    .armed_o (armed_o),
    .expire_o(expire)
  );

  txw_busy_ctrl u_busy (
    .clk          (clk),
    .rst          (rst),
    .expire_i     (expire),
    .access_busy_i(access_busy_i),
    .clear_i      (stop || deact_i),
    .busy_o       (busy_o),
    .evt_o        (evt)
  );

  assign pause_o   = evt.pause;
  assign resume_o  = evt.resume;
  assign discard_o = evt.discard;
  assign txrst_o   = evt.txrst;

  AST_PAUSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pause_o |=> !pause_o) else $error("pause held"); // R5
  AST_PAUSE_KEEPS_ARMED: assert property (@(posedge clk) disable iff (rst)
    pause_o |-> busy_o && armed_o) else $error("pause state"); // R5
  AST_DISCARD_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
    discard_o |-> txrst_o && !armed_o) else $error("discard state"); // R6
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (stop && !load_i) |=> !armed_o && !pause_o && !discard_o) else $error("stop"); // R4
  AST_DEACT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    deact_i |=> !armed_o && !busy_o) else $error("deact"); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(pause_o && discard_o)) else $error("two outcomes"); // R9
endmodule

// File: tb/dchan_busy_watchdog_tb.sv
module dchan_busy_watchdog_tb;
  localparam int TPM = 2;
  localparam int TMO = 5;
  localparam int FULL = TPM * TMO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b1, load_i = 1'b0, ready_i = 1'b0, underrun_i = 1'b0;
  logic deact_i = 1'b0, access_busy_i = 1'b0;
  logic armed_o, busy_o, pause_o, resume_o, discard_o, txrst_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dchan_busy_watchdog #(.TICKS_PER_MS(TPM), .TIMEOUT_MS(TMO)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i), .ready_i(ready_i),
    .underrun_i(underrun_i), .deact_i(deact_i), .access_busy_i(access_busy_i),
    .armed_o(armed_o), .busy_o(busy_o), .pause_o(pause_o), .resume_o(resume_o),
    .discard_o(discard_o), .txrst_o(txrst_o));

  function automatic logic [5:0] outs();
    return {armed_o, busy_o, pause_o, resume_o, discard_o, txrst_o};
  endfunction

  task automatic check(string req, logic [5:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: {armed,busy,pause,resume,discard,txrst} actual %b expected %b",
               req, outs(), exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_load();
    load_i = 1'b1; step(1); load_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 6'b000000);
  endtask

  task automatic t_expire_busy();
    access_busy_i = 1'b1;
    pulse_load();
    step(FULL - 1);
    check("R2 before expiry", 6'b100000);
    step(1);
    check("R5 pause", 6'b111000);
    step(1);
    check("R5 pause one cycle", 6'b110000);
    step(3 * FULL);
    check("R9 no second outcome", 6'b110000);
    access_busy_i = 1'b0;
    ready_i = 1'b1; step(1); ready_i = 1'b0;
    check("R7 ready resume", 6'b000100);
    step(1);
    check("R7 resume one cycle", 6'b000000);
  endtask

  task automatic t_expire_free();
    access_busy_i = 1'b0;
    pulse_load();
    step(FULL);
    check("R6 discard and reset", 6'b000011);
    step(1);
    check("R6 pulses one cycle", 6'b000000);
    step(2 * FULL);
    check("R9 nothing after discard", 6'b000000);
  endtask

  task automatic t_restart();
    pulse_load();
    step(FULL / 2 + 1);
    pulse_load();
    step(FULL - 1);
    check("R3 restart no early expiry", 6'b100000);
    step(1);
    check("R3 expiry after restart", 6'b000011);
    step(1);
  endtask

  task automatic t_ready_stop();
    pulse_load();
    step(3);
    ready_i = 1'b1; step(1); ready_i = 1'b0;
    check("R4 ready disarms, R7 no resume", 6'b000000);
    step(2 * FULL);
    check("R4 no expiry after stop", 6'b000000);
    pulse_load();
    step(2);
    underrun_i = 1'b1; step(1); underrun_i = 1'b0;
    check("R4 underrun disarms", 6'b000000);
    ready_i = 1'b1; load_i = 1'b1; step(1); ready_i = 1'b0; load_i = 1'b0;
    check("R4 load wins over ready", 6'b100000);
    step(FULL);
    check("R4 rearmed expiry", 6'b000011);
    step(1);
  endtask

  task automatic t_underrun_busy();
    access_busy_i = 1'b1;
    pulse_load();
    step(FULL);
    check("R5 pause again", 6'b111000);
    access_busy_i = 1'b0;
    underrun_i = 1'b1; step(1); underrun_i = 1'b0;
    check("R7 underrun resume", 6'b000100);
    step(1);
  endtask

  task automatic t_deact();
    access_busy_i = 1'b1;
    pulse_load();
    step(FULL + 1);
    check("R5 busy held", 6'b110000);
    deact_i = 1'b1; load_i = 1'b1; step(1); deact_i = 1'b0; load_i = 1'b0;
    check("R8 deact clears busy with resume, beats load", 6'b000100);
    access_busy_i = 1'b0;
    pulse_load();
    step(2);
    deact_i = 1'b1; step(1); deact_i = 1'b0;
    check("R8 deact disarms no resume", 6'b000000);
    step(2 * FULL);
    check("R8 no expiry after deact", 6'b000000);
  endtask

  task automatic t_tick_gate();
    tick_i = 1'b0;
    pulse_load();
    step(4 * FULL);
    check("R2 no count without tick", 6'b100000);
    tick_i = 1'b1;
    step(FULL - 1);
    check("R2 before gated expiry", 6'b100000);
    step(1);
    check("R2 gated expiry", 6'b000011);
    step(1);
  endtask

  initial begin
    #1;
    step(3);
    rst = 1'b0;
    t_reset();
    t_expire_busy();
    t_expire_free();
    t_restart();
    t_ready_stop();
    t_underrun_busy();
    t_deact();
    t_tick_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule